// File: doc/BRIEF.md
# Infrared Frame Preamble Sequencer

This block produces the opening characters that come before the payload of an infrared serial frame. Software programs an 8-bit length value into a 16-bit register word. A frame start request then makes the block hand a run of opening characters to a downstream byte serializer over a valid/ready handshake. After the serializer has accepted the last opening character, the block pulses a done flag so that the payload logic can take over.

The mode input selects how the length value is read. In slow (SIR) mode the value counts the main beginning-of-frame character together with the extra ones that follow it, and a value of zero gives the longest preamble. In medium-rate (MIR) mode two start flags are always sent, and the value adds that many more flags. The block captures the length value and the mode when the start is accepted, so later register writes or mode changes affect only the next frame.

Top module: `irda_preamble_seq`

## Requirements
- R1: After reset, reg_rdata_o is 0, char_valid_o is 0, busy_o is 0 and done_o is 0.
- R2: A write (reg_we_i high at a clock edge) stores reg_wdata_i[7:0] as the length. reg_rdata_o returns the length in bits [7:0], and bits [15:8] always read as 0.
- R3: In SIR mode (mode_mir_i = 0) with length 1, exactly one character is sent, 0xC0.
- R4: In SIR mode with length n+1 (n from 1 to 254), the sequence is 0xC0 followed by n characters of 0xFF.
- R5: In SIR mode with length 0, the sequence is 0xC0 followed by 255 characters of 0xFF, for 256 characters in total.
- R6: In MIR mode (mode_mir_i = 1) with length L, the sequence is L+2 characters, each 0x7E.
- R7: The length and the mode are captured at the clock edge where start_i is accepted while the block is idle. A register write or a change of mode_mir_i during a preamble leaves that preamble unchanged.
- R8: done_o is high for exactly one cycle: the cycle after the edge at which the final character is accepted. In that same cycle busy_o and char_valid_o are 0.
- R9: While char_valid_o is high and char_ready_i is low, char_data_o and the remaining count do not change, and no character is consumed.
- R10: start_i is ignored while busy_o is high. The preamble in progress is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Length register write strobe |
| reg_wdata_i | input | 16 | Register write word; only bits [7:0] are stored |
| reg_rdata_o | output | 16 | Register read word, upper byte zero |
| mode_mir_i | input | 1 | 0 selects SIR, 1 selects MIR |
| start_i | input | 1 | Frame start request, taken only while idle |
| busy_o | output | 1 | Preamble in progress |
| char_valid_o | output | 1 | Character offered to the serializer |
| char_data_o | output | 8 | Character value |
| char_ready_i | input | 1 | Serializer accepts the character |
| done_o | output | 1 | One-cycle pulse after the last character is accepted |

## Verification
The bench goes after the count boundaries. With SIR length 1 a design that counted only the extra characters would send two characters. With SIR length 0 a design that took zero literally would send one character or none instead of 256. With MIR length 255 a counter that is too narrow would wrap and fall short of 257 flags. Random backpressure exposes a design that drops or repeats a character on a stalled beat. A register write, a mode flip and a stray start issued in the middle of a frame catch a design that reads the length or the mode live, or that restarts. Done timing is checked on the exact cycle, so an early, late or stretched pulse is reported.

// File: rtl/ir_pre_pkg.sv
package ir_pre_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } ir_pre_state_e;

  localparam logic [7:0] SIR_BOF_CHAR  = 8'hC0;
  localparam logic [7:0] SIR_XBOF_CHAR = 8'hFF;
  localparam logic [7:0] MIR_FLAG_CHAR = 8'h7E;
endpackage

// File: rtl/ir_len_reg.sv
module ir_len_reg #(
  parameter int LEN_W = 8,
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LEN_W-1:0] wdata_i,
  output logic [LEN_W-1:0] len_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else if (we_i) len_q <= wdata_i;
  end

  assign len_o   = len_q;
  assign rdata_o = {{(REG_W-LEN_W){1'b0}}, len_q};
endmodule

// File: rtl/ir_pre_len_calc.sv
module ir_pre_len_calc #(
  parameter int LEN_W   = 8,
  parameter int CNT_W   = LEN_W + 1,
  parameter int MIR_MIN = 2
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             mir_i,
  output logic [CNT_W-1:0] total_o
);
  localparam logic [CNT_W-1:0] SIR_WRAP = CNT_W'(1) << LEN_W;
  localparam logic [CNT_W-1:0] MIR_ADD  = CNT_W'(MIR_MIN);

  logic [CNT_W-1:0] len_ext;
  assign len_ext = CNT_W'(len_i);

  always_comb begin
    if (mir_i)            total_o = len_ext + MIR_ADD;
    else if (len_i == '0) total_o = SIR_WRAP;  // zero selects the longest SIR run
    else                  total_o = len_ext;
  end
endmodule

// File: rtl/ir_pre_ctrl.sv
module ir_pre_ctrl
  import ir_pre_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mir_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic             first_o,
  output logic             mir_q_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             done_o
);
  ir_pre_state_e    state_q;
  logic [CNT_W-1:0] rem_q;
  logic             first_q, mir_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      first_q <= 1'b0;
      mir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SEND;
            rem_q   <= total_i;
            first_q <= 1'b1;
            mir_q   <= mir_i;
          end
        end
        ST_SEND: begin
          if (ready_i) begin
            first_q <= 1'b0;
            if (rem_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              rem_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              rem_q <= rem_q - CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == ST_SEND);
  assign first_o     = first_q;
  assign mir_q_o     = mir_q;
  assign remaining_o = rem_q;
  assign done_o      = done_q;
endmodule

// File: rtl/ir_pre_char_sel.sv
module ir_pre_char_sel
  import ir_pre_pkg::*;
(
  input  logic       mir_i,
  input  logic       first_i,
  output logic [7:0] char_o
);
  always_comb begin
    if (mir_i)        char_o = MIR_FLAG_CHAR;
    else if (first_i) char_o = SIR_BOF_CHAR;
    else              char_o = SIR_XBOF_CHAR;
  end
endmodule

// File: rtl/irda_preamble_seq.sv
module irda_preamble_seq #(
  parameter int LEN_W   = 8,
  parameter int REG_W   = 16,
  parameter int MIR_MIN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             mode_mir_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             char_valid_o,
  output logic [7:0]       char_data_o,
  input  logic             char_ready_i,
  output logic             done_o
);
  localparam int CNT_W = LEN_W + 1;

  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] total, remaining;
  logic             first, mode_q, busy;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:LEN_W];

  ir_len_reg #(.LEN_W(LEN_W), .REG_W(REG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i[LEN_W-1:0]),
    .len_o   (len),
    .rdata_o (reg_rdata_o)
  );

  ir_pre_len_calc #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MIR_MIN(MIR_MIN)) u_calc (
    .len_i   (len),
    .mir_i   (mode_mir_i),
    .total_o (total)
  );

  ir_pre_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mir_i       (mode_mir_i),
    .total_i     (total),
    .ready_i     (char_ready_i),
    .busy_o      (busy),
    .first_o     (first),
    .mir_q_o     (mode_q),
    .remaining_o (remaining),
    .done_o      (done_o)
  );

  ir_pre_char_sel u_sel (
    .mir_i   (mode_q),
    .first_i (first),
    .char_o  (char_data_o)
  );

  assign busy_o       = busy;
  assign char_valid_o = busy;
endmodule

// File: rtl/ir_pre_checker.sv
module ir_pre_checker
  import ir_pre_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_i,
  input logic [7:0]       data_i,
  input logic             done_i,
  input logic             busy_i,
  input logic             mode_q_i,
  input logic [CNT_W-1:0] rem_i
);
  a_r9_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(data_i));

  a_r9_hold_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> $stable(rem_i));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r8_done_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(valid_i && ready_i) && !busy_i && !valid_i);

  a_r4_first_bof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) && !mode_q_i |-> data_i == SIR_BOF_CHAR);

  a_r6_mir_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_q_i |-> data_i == MIR_FLAG_CHAR);

  a_r7_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !(valid_i && ready_i) |=> busy_i && $stable(mode_q_i));
endmodule

bind irda_preamble_seq ir_pre_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (char_valid_o),
  .ready_i  (char_ready_i),
  .data_i   (char_data_o),
  .done_i   (done_o),
  .busy_i   (busy_o),
  .mode_q_i (mode_q),
  .rem_i    (remaining)
);

// File: tb/sim_irda_preamble_seq.sv
`timescale 1ns/1ps
module sim_irda_preamble_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mode_mir = 1'b0;
  logic        start = 1'b0;
  logic        busy, cvalid, cready, done;
  logic [7:0]  cdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irda_preamble_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .mode_mir_i(mode_mir), .start_i(start),
    .busy_o(busy), .char_valid_o(cvalid), .char_data_o(cdata),
    .char_ready_i(cready), .done_o(done)
  );

  function automatic int exp_total(input logic [7:0] len, input bit mir);
    if (mir) return int'(len) + 2;
    if (len == 8'd0) return 256;
    return int'(len);
  endfunction

  function automatic logic [7:0] exp_char(input int idx, input bit mir);
    if (mir) return 8'h7E;
    return (idx == 0) ? 8'hC0 : 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_len(input logic [15:0] w);
    reg_we = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // disturb: mid-frame register write, mode flip and stray start
  task automatic run_frame(input logic [7:0] len, input bit mir, input int rdy_pct,
                           input bit disturb, input string req);
    int total, got, guard, bad_idx;
    logic [7:0] bad_act;
    bit seq_ok, disturbed;
    write_len({8'h00, len});
    total = exp_total(len, mir);
    mode_mir = mir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && cvalid === 1'b1, req, int'(busy), 1);
    got = 0; guard = 0; seq_ok = 1'b1; disturbed = 1'b0; bad_idx = 0; bad_act = 0;
    while (got < total && guard < 20000) begin
      cready = ($urandom_range(99) < rdy_pct);
      if (disturb && !disturbed && got == 1) begin
        disturbed = 1'b1;
        reg_we = 1'b1; reg_wdata = {8'h5A, ~len};
        mode_mir = ~mir; start = 1'b1;
      end
      #1;
      if (cvalid !== 1'b1 || cdata !== exp_char(got, mir)) begin
        if (seq_ok) begin bad_idx = got; bad_act = cdata; end
        seq_ok = 1'b0;
      end
      if (cready) got++;
      @(negedge clk);
      reg_we = 1'b0; start = 1'b0;
      guard++;
    end
    check(seq_ok, {req, " sequence"}, int'(bad_act), int'(exp_char(bad_idx, mir)));
    check(got == total, {req, " count"}, got, total);
    cready = 1'b0;
    #1;
    check(done === 1'b1 && busy === 1'b0 && cvalid === 1'b0, "R8 done on cycle after last accept",
          int'(done), 1);
    @(negedge clk);
    check(done === 1'b0 && cvalid === 1'b0, "R8 done single cycle / no extra char R10",
          int'(done), 0);
    if (disturb)
      check(reg_rdata === {8'h00, ~len}, "R7 write during preamble stored for next frame",
            int'(reg_rdata), int'({8'h00, ~len}));
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cready = 1'b0;
    void'($urandom(32'd1234));
    #25;
    check(reg_rdata === 16'h0 && cvalid === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1 reset state", int'(reg_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata === 16'h0 && cvalid === 1'b0, "R1 after release", int'(reg_rdata), 0);

    write_len(16'hA53C);
    check(reg_rdata === 16'h003C, "R2 upper byte zero", int'(reg_rdata), 16'h003C);
    write_len(16'hFF81);
    check(reg_rdata === 16'h0081, "R2 readback", int'(reg_rdata), 16'h0081);

    run_frame(8'd1,   1'b0, 100, 1'b0, "R3 SIR len1");
    run_frame(8'd2,   1'b0, 100, 1'b0, "R4 SIR len2");
    run_frame(8'd7,   1'b0, 50,  1'b0, "R4 SIR len7 stalled R9");
    run_frame(8'd0,   1'b0, 80,  1'b0, "R5 SIR len0");
    run_frame(8'd255, 1'b0, 100, 1'b0, "R4 SIR len255");
    run_frame(8'd0,   1'b1, 100, 1'b0, "R6 MIR len0");
    run_frame(8'd255, 1'b1, 70,  1'b0, "R6 MIR len255");
    run_frame(8'd5,   1'b0, 60,  1'b1, "R7 SIR disturbed R10");
    run_frame(8'd3,   1'b1, 60,  1'b1, "R7 MIR disturbed R10");
    run_frame(8'd1,   1'b0, 20,  1'b0, "R9 SIR len1 heavy stall");

    for (int i = 0; i < 16; i++) begin
      logic [7:0] l;
      bit m;
      l = 8'($urandom_range(255));
      m = 1'($urandom_range(1));
      run_frame(l, m, 30 + $urandom_range(70), 1'($urandom_range(1)),
                m ? "R6 random MIR" : "R4 random SIR");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule